// File: doc/BRIEF.md
# Instruction Prefetch Queue

This block sits between a 16-bit code fetch port and an instruction decoder. It keeps a small byte buffer (six bytes by default) topped up with code. Whenever the buffer has room for a whole word, it asks the fetch port for the next two-byte word from a running fetch address. The decoder takes bytes out one at a time, lowest address first, through a valid/ready handshake.

A flush, raised when a branch is taken, empties the buffer and reloads the fetch address from the branch target. If a word fetch is still outstanding at that moment, it is allowed to complete and its data is dropped. When the target is odd, only the upper byte of the first fetched word is kept. Once a configurable halt opcode lands in the buffer, no further fetches are started until the next flush. Bytes already buffered are still handed to the decoder.

Fetch port rules: `fetch_req_o` rises with a word-aligned address. Both stay fixed until the cycle in which `fetch_ack_i` is high, and `fetch_data_i` is taken in that same cycle. Byte `[7:0]` belongs to the even address. Only one fetch is ever outstanding. Decoder rules: a byte moves only in a cycle where `byte_valid_o` and `byte_ready_i` are both high. While `byte_ready_i` is low, the presented byte is held unchanged. Back-pressure from the decoder therefore only fills the buffer, and the fill in turn throttles the fetch requests.

Top module: `prefetch_queue`

## Requirements
- R1: After reset the queue is empty (`byte_valid_o` low) and no request is pending. The first request goes out at parameter `RESET_ADDR` (default 0) in the first cycle after reset is released.
- R2: A new fetch request rises only when no fetch is outstanding, no halt is latched, no flush is present, and the queue holds at most DEPTH-2 bytes, counted in the cycle before the request rises.
- R3: While `fetch_req_o` is high and `fetch_ack_i` is low, the request and `fetch_addr_o` stay unchanged. Addresses are even, and consecutive accepted fetches are 2 apart.
- R4: Bytes reach the decoder in address order: bits [7:0] of an accepted word come before bits [15:8].
- R5: `byte_valid_o` is high exactly when the queue is non-empty. At most one byte leaves per cycle. A byte that is offered but not taken stays on `byte_data_o` unchanged.
- R6: The queue never holds more than DEPTH bytes. With the decoder stalled, the queue fills to DEPTH and the fetch requests stop.
- R7: When `flush_i` is high, the queue is empty in the next cycle. No byte is consumed in the flush cycle. The next request uses the target address with bit 0 cleared.
- R8: A fetch outstanding at a flush completes normally on the port, but its data is discarded and leaves the queue unchanged.
- R9: After a flush to an odd target, the first accepted word contributes only its bits [15:8], so the first delivered byte is the one at the target address.
- R10: Once a byte equal to parameter `HALT_OP` (default 8'hF4) is written into the queue, no new request is issued until a flush. Bytes already queued are still delivered.
- R11: A flush clears a latched halt, and fetching resumes from the new target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Taken branch: empty the queue and reload the fetch address |
| flush_addr_i | input | ADDR_W | Branch target byte address |
| fetch_req_o | output | 1 | Word fetch request |
| fetch_addr_o | output | ADDR_W | Word-aligned fetch address |
| fetch_ack_i | input | 1 | Fetch completes this cycle, data valid |
| fetch_data_i | input | 16 | Fetched code word, [7:0] at the even address |
| byte_valid_o | output | 1 | A code byte is presented |
| byte_data_o | output | 8 | Presented code byte |
| byte_ready_i | input | 1 | Decoder takes the presented byte |

## Verification
The bench models the queue as a byte list fed from a code function of the address. It checks the valid flag, the head byte, the request line and the request address every cycle, while the acknowledge latency, the decoder stalls and the flush timing are randomised. Several corner cases get targeted stimulus:
- Flushes that land while a fetch is outstanding. A design that kept that word would deliver bytes from the old path.
- Odd branch targets. Keeping the low byte would put an extra byte before the target.
- Long decoder stalls. Overcounting free room would overflow the buffer; undercounting would starve the decoder.
- Halt opcodes placed just past a branch target. A design that ignored the halt would keep requesting.
- A flush after a halt. A design that never released the halt would stop fetching for good.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  typedef logic [7:0] pfq_byte_t;

  function automatic int pfq_cnt_w(input int depth);
    return $clog2(depth + 1);
  endfunction

  function automatic int pfq_ptr_w(input int depth);
    return (depth > 2) ? $clog2(depth) : 1;
  endfunction
endpackage

// File: rtl/pfq_byte_store.sv
module pfq_byte_store
  import pfq_pkg::*;
#(
  parameter int DEPTH = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clear_i,
  input  logic                        wr_lo_i,
  input  logic                        wr_hi_i,
  input  logic [15:0]                 wr_data_i,
  input  logic                        rd_i,
  output pfq_byte_t                   rd_data_o,
  output logic [pfq_cnt_w(DEPTH)-1:0] count_o
);
  localparam int CNT_W = pfq_cnt_w(DEPTH);
  localparam int PTR_W = pfq_ptr_w(DEPTH);

  pfq_byte_t        slot_q [DEPTH];
  logic [PTR_W-1:0] rd_ptr_q, wr_ptr_q, wr_ptr_nx1;
  logic [CNT_W-1:0] count_q;
  logic             first_en, second_en;
  pfq_byte_t        first_byte;
  logic [1:0]       n_push;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign first_en   = wr_lo_i | wr_hi_i;
  assign second_en  = wr_lo_i & wr_hi_i;
  assign first_byte = wr_lo_i ? wr_data_i[7:0] : wr_data_i[15:8];
  assign n_push     = {1'b0, first_en} + {1'b0, second_en};
  assign wr_ptr_nx1 = step(wr_ptr_q);

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (!clear_i && first_en && wr_ptr_q == PTR_W'(i))
        slot_q[i] <= first_byte;
      else if (!clear_i && second_en && wr_ptr_nx1 == PTR_W'(i))
        slot_q[i] <= wr_data_i[15:8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (rd_i) rd_ptr_q <= step(rd_ptr_q);
      if (second_en)     wr_ptr_q <= step(wr_ptr_nx1);
      else if (first_en) wr_ptr_q <= wr_ptr_nx1;
      count_q <= count_q + CNT_W'(n_push) - CNT_W'(rd_i);
    end
  end

  assign rd_data_o = slot_q[rd_ptr_q];
  assign count_o   = count_q;

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && first_en) |-> (int'(count_q) + int'(n_push) <= DEPTH));
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |-> (count_q != '0));
endmodule

// File: rtl/pfq_fetch_ctrl.sv
module pfq_fetch_ctrl
  import pfq_pkg::*;
#(
  parameter int        DEPTH      = 6,
  parameter int        ADDR_W     = 24,
  parameter pfq_byte_t HALT_OP    = 8'hF4,
  parameter int        RESET_ADDR = 0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        flush_i,
  input  logic [ADDR_W-1:0]           flush_addr_i,
  input  logic                        fetch_ack_i,
  input  logic [15:0]                 fetch_data_i,
  input  logic [pfq_cnt_w(DEPTH)-1:0] fill_i,
  output logic                        fetch_req_o,
  output logic [ADDR_W-1:0]           fetch_addr_o,
  output logic                        wr_lo_o,
  output logic                        wr_hi_o
);
  localparam int CNT_W = pfq_cnt_w(DEPTH);
  localparam logic [CNT_W-1:0] ROOM_MAX = CNT_W'(DEPTH - 2);

  logic [ADDR_W-1:0] next_addr_q, req_addr_q;
  logic              req_q, discard_q, skip_lo_q, halt_q;
  logic              accept, halt_hit, can_issue, done;

  assign done      = req_q & fetch_ack_i;
  assign accept    = done & ~flush_i & ~discard_q;
  assign wr_lo_o   = accept & ~skip_lo_q;
  assign wr_hi_o   = accept;
  assign halt_hit  = (wr_lo_o && fetch_data_i[7:0] == HALT_OP) ||
                     (wr_hi_o && fetch_data_i[15:8] == HALT_OP);
  assign can_issue = ~req_q & ~halt_q & (fill_i <= ROOM_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      next_addr_q <= ADDR_W'(RESET_ADDR) & ~ADDR_W'(1);
      req_addr_q  <= '0;
      req_q       <= 1'b0;
      discard_q   <= 1'b0;
      skip_lo_q   <= 1'b0;
      halt_q      <= 1'b0;
    end else if (flush_i) begin
      next_addr_q <= {flush_addr_i[ADDR_W-1:1], 1'b0};
      skip_lo_q   <= flush_addr_i[0];
      halt_q      <= 1'b0;
      req_q       <= req_q & ~fetch_ack_i;
      discard_q   <= req_q & ~fetch_ack_i;
    end else if (done) begin
      req_q     <= 1'b0;
      discard_q <= 1'b0;
      if (!discard_q) begin
        next_addr_q <= next_addr_q + ADDR_W'(2);
        skip_lo_q   <= 1'b0;
        if (halt_hit) halt_q <= 1'b1;
      end
    end else if (can_issue) begin
      req_q      <= 1'b1;
      req_addr_q <= next_addr_q;
    end
  end

  assign fetch_req_o  = req_q;
  assign fetch_addr_o = req_addr_q;

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req_o && !fetch_ack_i) |=> (fetch_req_o && $stable(fetch_addr_o)));
  assert_even_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req_o |-> !fetch_addr_o[0]);
  assert_room_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_req_o && !flush_i) |=> (fetch_req_o -> ($past(fill_i) <= ROOM_MAX)));
  assert_halt_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && !flush_i) |=> !fetch_req_o);
  assert_discard_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (discard_q && fetch_ack_i) |-> !(wr_lo_o || wr_hi_o));
endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue
  import pfq_pkg::*;
#(
  parameter int        DEPTH      = 6,
  parameter int        ADDR_W     = 24,
  parameter pfq_byte_t HALT_OP    = 8'hF4,
  parameter int        RESET_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic [ADDR_W-1:0] flush_addr_i,
  output logic              fetch_req_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  input  logic              fetch_ack_i,
  input  logic [15:0]       fetch_data_i,
  output logic              byte_valid_o,
  output logic [7:0]        byte_data_o,
  input  logic              byte_ready_i
);
  localparam int CNT_W = pfq_cnt_w(DEPTH);

  logic [CNT_W-1:0] fill;
  logic             wr_lo, wr_hi, pop;

  assign byte_valid_o = (fill != '0);
  assign pop          = byte_valid_o & byte_ready_i & ~flush_i;

  pfq_fetch_ctrl #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .HALT_OP(HALT_OP), .RESET_ADDR(RESET_ADDR)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .flush_addr_i(flush_addr_i),
    .fetch_ack_i(fetch_ack_i), .fetch_data_i(fetch_data_i), .fill_i(fill),
    .fetch_req_o(fetch_req_o), .fetch_addr_o(fetch_addr_o),
    .wr_lo_o(wr_lo), .wr_hi_o(wr_hi)
  );

  pfq_byte_store #(.DEPTH(DEPTH)) store_i (
    .clk(clk), .rst_n(rst_n), .clear_i(flush_i), .wr_lo_i(wr_lo), .wr_hi_i(wr_hi),
    .wr_data_i(fetch_data_i), .rd_i(pop), .rd_data_o(byte_data_o), .count_o(fill)
  );

  assert_flush_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !byte_valid_o);
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid_o && !byte_ready_i && !flush_i) |=> (byte_valid_o && $stable(byte_data_o)));
  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (!byte_valid_o && !fetch_req_o));
endmodule

// File: tb/prefetch_queue_tb.sv
module prefetch_queue_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 6;
  localparam int AW         = 24;
  localparam logic [7:0] HALT = 8'hF4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          flush_i = 1'b0;
  logic [AW-1:0] flush_addr_i = '0;
  logic          fetch_req_o;
  logic [AW-1:0] fetch_addr_o;
  logic          fetch_ack_i = 1'b0;
  logic [15:0]   fetch_data_i = '0;
  logic          byte_valid_o;
  logic [7:0]    byte_data_o;
  logic          byte_ready_i = 1'b0;

  prefetch_queue dut_i (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .flush_addr_i(flush_addr_i),
    .fetch_req_o(fetch_req_o), .fetch_addr_o(fetch_addr_o), .fetch_ack_i(fetch_ack_i),
    .fetch_data_i(fetch_data_i), .byte_valid_o(byte_valid_o), .byte_data_o(byte_data_o),
    .byte_ready_i(byte_ready_i)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  finished = 1'b0;
  int  halt_at  = -1;

  logic [7:0] mq[$];
  int  pc = 0, pend_addr = 0;
  bit  pend = 0, disc = 0, halted = 0, skip = 0;
  bit  odd_first = 0, first_pending = 0, after_flush = 0, disc_ack = 0, resumed = 0;

  function automatic logic [7:0] code_at(input int a);
    logic [7:0] v;
    if (a == halt_at) return HALT;
    v = 8'((a * 37 + 11) & 255);
    if (v == HALT) v = 8'h21;
    return v;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!byte_valid_o, "R1", "valid in reset", int'(byte_valid_o), 0);
    check(!fetch_req_o, "R1", "request in reset", int'(fetch_req_o), 0);
    rst_n = 1'b1;
    for (int cyc = 0; cyc < 6000; cyc++) begin
      int  phase = cyc / 1000;
      bit  rdy, ack, fl, pop, ackm;
      int  tgt, sz;
      string vtag, rtag, dtag;

      vtag = after_flush ? "R7" : (disc_ack ? "R8" : "R5");
      check(byte_valid_o == (mq.size() != 0), vtag, "byte_valid", int'(byte_valid_o),
            int'(mq.size() != 0));
      if (byte_valid_o && mq.size() != 0) begin
        dtag = (first_pending && odd_first) ? "R9" : "R4";
        check(byte_data_o == mq[0], dtag, "byte_data", int'(byte_data_o), int'(mq[0]));
      end
      rtag = halted ? "R10" : (resumed ? "R11" : (mq.size() >= DEPTH - 1 ? "R6" : "R2"));
      check(fetch_req_o == pend, rtag, "fetch_req", int'(fetch_req_o), int'(pend));
      if (fetch_req_o && pend) begin
        dtag = (cyc == 0) ? "R1" : "R3";
        check(fetch_addr_o == AW'(pend_addr), dtag, "fetch_addr", int'(fetch_addr_o), pend_addr);
      end
      after_flush = 0;
      disc_ack    = 0;

      case (phase)
        0: begin rdy = 1; ack = 1; end
        1: begin rdy = ($urandom % 2) == 0; ack = ($urandom % 2) == 0; end
        2: begin rdy = (cyc % 50) >= 35; ack = ($urandom % 3) != 0; end
        3: begin rdy = ($urandom % 3) != 0; ack = ($urandom % 4) == 0; end
        default: begin rdy = ($urandom % 4) != 0; ack = ($urandom % 2) == 0; end
      endcase
      ack = ack && fetch_req_o;
      fl = 0;
      if (phase == 1 && ($urandom % 40) == 0) fl = 1;
      if (phase == 3 && ($urandom % 12) == 0) fl = 1;
      if (phase >= 4 && ($urandom % 60) == 0) fl = 1;
      tgt = 'h100 + int'($urandom % 256);
      if (fl && phase >= 4) halt_at = tgt + 3 + int'($urandom % 10);

      pop  = byte_valid_o && rdy && !fl;
      ackm = ack && pend;
      sz   = mq.size();
      if (fl) begin
        if (halted) resumed = 1;
        mq.delete();
        disc = pend && !ackm;
        pend = pend && !ackm;
        pc = tgt & ~1;
        skip = tgt[0];
        halted = 0;
        odd_first = tgt[0];
        first_pending = 1;
        after_flush = 1;
      end else begin
        if (pop && sz > 0) begin
          void'(mq.pop_front());
          first_pending = 0;
        end
        if (ackm) begin
          if (!disc) begin
            if (!skip) begin
              mq.push_back(code_at(pend_addr));
              if (code_at(pend_addr) == HALT) halted = 1;
            end
            mq.push_back(code_at(pend_addr + 1));
            if (code_at(pend_addr + 1) == HALT) halted = 1;
            pc = pc + 2;
            skip = 0;
          end else disc_ack = 1;
          pend = 0;
          disc = 0;
        end else if (!pend && !halted && sz <= DEPTH - 2) begin
          pend = 1;
          pend_addr = pc;
          resumed = 0;
        end
      end

      byte_ready_i = rdy;
      fetch_ack_i  = ack;
      fetch_data_i = ack ? {code_at(int'(fetch_addr_o) + 1), code_at(int'(fetch_addr_o))} : 16'h0;
      flush_i      = fl;
      flush_addr_i = AW'(tgt);
      @(negedge clk);
    end
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL R1 watchdog expired actual=%0h expected=%0h", 0, 1);
      summary();
      $finish;
    end
  end
endmodule